// File: doc/BRIEF.md
# Setup-Driven Conversion Scheduler

This block models the command-side timing of a multi-setup measurement converter. It holds eight 16-bit conversion setups, packed two to a 32-bit register in a four-register bank. A host loads the bank one register at a time or as a bulk sequence. A start command names one setup through a 3-bit pointer and asks for either single or continuous conversion. The block copies that setup into an active slot and drives the front-end select pins from it: channel, gain range, polarity, current-source enable and two latch outputs. It can then hold for a fixed settling delay, and after that it emits one-cycle data-ready strobes at the word rate that the setup selects.

One global rate-family input chooses between two timing families. When it is set, every word period and the latch settling delay are stretched by 6/5. The word period is the fastest-rate period shifted left by (9 - rate code). The first word of a run and every single-mode word take three word periods, which models the settling of the filter. The filter arithmetic itself is outside this block.

Top module: `conv_scheduler`

## Requirements
- R1: After reset, every bank register reads 32'h0400_0400 and busy, data_ready, start_ignored, both latch pins, the channel (0 meaning the first channel), gain, unipolar and current-enable outputs are all 0. Setup fields are: bits 3:0 channel, 6:4 gain code, 7 unipolar (0 bipolar), 11:8 rate code, 12 latch 0, 13 latch 1, 14 current-source enable, 15 delay enable. The default setup therefore has rate code 4.
- R2: A non-bulk write replaces the whole 32-bit register at reg_waddr. Setup 2k sits in bits 15:0 of register k and setup 2k+1 in bits 31:16. A read returns the register's content on reg_rdata one cycle after reg_re, and that content is the value from before any write in the same cycle.
- R3: With the bulk bit set, successive writes target registers 0,1,2,3,0,… through a write pointer, and successive reads do the same through a separate read pointer. A non-bulk access sets its own pointer back to 0.
- R4: A start while idle copies the setup chosen by start_ptr into the active slot. From the cycle after the start edge, the select and latch outputs show that setup and busy is 1. Later bank writes do not change these outputs.
- R5: The word period is P = B << (9 - code) for codes 0..9, and codes 10..15 behave as code 9. B is BASE_PERIOD when rate_alt is 0 and BASE_PERIOD*6/5 when it is 1. rate_alt is sampled at the start edge.
- R6: In single mode, data_ready pulses for one cycle, 3*P cycles after the start edge (plus the delay when enabled). Busy falls on the same edge, and no further pulse follows.
- R7: In continuous mode, the first pulse comes 3*P cycles (plus the delay) after the start edge and each later pulse P cycles after the one before, until a stop.
- R8: With the delay bit set, the first word is held back by DLY_STD cycles when rate_alt was 0 at start, or by DLY_ALT cycles when it was 1.
- R9: A stop while busy clears busy on the next edge, and no pulse follows until a new start. The select and latch pins keep their values. A stop while idle has no effect.
- R10: A start while busy has no effect on the timing or the outputs, and it sets start_ignored, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_alt | input | 1 | Rate-family select (0 base, 1 stretched by 6/5) |
| reg_we | input | 1 | Bank write strobe |
| reg_wbulk | input | 1 | Write uses the bulk pointer instead of reg_waddr |
| reg_waddr | input | 2 | Register index for non-bulk write |
| reg_wdata | input | 32 | Register write data |
| reg_re | input | 1 | Bank read strobe |
| reg_rbulk | input | 1 | Read uses the bulk pointer instead of reg_raddr |
| reg_raddr | input | 2 | Register index for non-bulk read |
| reg_rdata | output | 32 | Registered read data |
| start | input | 1 | Start command |
| start_ptr | input | 3 | Setup pointer for the start command |
| start_cont | input | 1 | 1 continuous, 0 single |
| stop | input | 1 | Halt a running conversion |
| latch_out | output | 2 | Latch pins from the active setup |
| chan_sel | output | 4 | Channel select |
| gain_sel | output | 3 | Gain range code |
| unipolar | output | 1 | Polarity select |
| ocs_en | output | 1 | Open-circuit current-source enable |
| busy | output | 1 | A conversion sequence is active |
| data_ready | output | 1 | One-cycle conversion-done strobe |
| start_ignored | output | 1 | Sticky flag: a start arrived while busy |

## Verification
Some properties are checked on every cycle. A stop clears busy and suppresses the strobe. The select pins change only on an accepted start. A strobe appears only while a sequence was running. A start during a run sets the sticky flag, which then never falls. Only the bench's scenarios can show the rest. Those are the exact strobe instants for each rate code and family, the added settling delay, the three-period first word, the bank layout and both bulk pointers. The bench compares all of these cycle by cycle against a timestamp model of the start edge.

// File: rtl/sched_pkg.sv
package sched_pkg;

   typedef struct packed {
      logic       dly;
      logic       ocs;
      logic [1:0] lat;
      logic [3:0] rate;
      logic       unip;
      logic [2:0] gain;
      logic [3:0] chan;
   } setup_t;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_DELAY,
      PH_SETTLE,
      PH_RUN
   } phase_t;

   localparam int unsigned SETUP_W   = $bits(setup_t);
   localparam int unsigned RATE_TOP  = 9;
   localparam logic [SETUP_W-1:0] SETUP_DEFAULT = 16'h0400;

endpackage

// File: rtl/sched_setup_bank.sv
module sched_setup_bank
   import sched_pkg::*;
#(
   parameter int unsigned NREG = 4,
   parameter int unsigned RW   = 32,
   localparam int unsigned SPR = RW / SETUP_W,
   localparam int unsigned AW  = $clog2(NREG),
   localparam int unsigned HB  = $clog2(SPR),
   localparam int unsigned PW  = AW + HB
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic          wbulk,
   input  logic [AW-1:0] waddr,
   input  logic [RW-1:0] wdata,
   input  logic          re,
   input  logic          rbulk,
   input  logic [AW-1:0] raddr,
   output logic [RW-1:0] rdata,
   input  logic [PW-1:0] sel_ptr,
   output setup_t        sel_setup
);

   generate
      if (SPR < 2 || SPR * SETUP_W != RW) begin : g_bad_width
         $error("register width must hold a whole number (>=2) of setups");
      end
      if ((1 << AW) != NREG) begin : g_bad_depth
         $error("register count must be a power of two");
      end
   endgenerate

   logic [RW-1:0] regs_q [NREG];
   logic [AW-1:0] wptr_q, rptr_q;
   logic [AW-1:0] wa, ra;

   assign wa = wbulk ? wptr_q : waddr;
   assign ra = rbulk ? rptr_q : raddr;

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs_q[g] <= {SPR{SETUP_DEFAULT}};
         else if (we && wa == AW'(g))
            regs_q[g] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
         rdata  <= '0;
      end else begin
         if (we)
            wptr_q <= wbulk ? wptr_q + 1'b1 : '0;
         if (re) begin
            rptr_q <= rbulk ? rptr_q + 1'b1 : '0;
            rdata  <= regs_q[ra];
         end
      end
   end

   logic [RW-1:0] sel_word;
   assign sel_word  = regs_q[sel_ptr[PW-1:HB]];
   assign sel_setup = setup_t'(sel_word[sel_ptr[HB-1:0]*SETUP_W +: SETUP_W]);

endmodule

// File: rtl/sched_period_calc.sv
module sched_period_calc
   import sched_pkg::*;
#(
   parameter int unsigned BASE_PERIOD  = 1280,
   parameter int unsigned DLY_STD      = 1280,
   parameter int unsigned DLY_ALT      = 1536,
   parameter int unsigned SETTLE_WORDS = 3,
   parameter int unsigned CW           = 22
) (
   input  logic [3:0]    rate,
   input  logic          alt,
   output logic [CW-1:0] period,
   output logic [CW-1:0] settle,
   output logic [CW-1:0] delay
);

   localparam int unsigned BASE_ALT = BASE_PERIOD * 6 / 5;

   generate
      if (BASE_PERIOD % 5 != 0) begin : g_bad_base
         $error("BASE_PERIOD must be a multiple of 5 for the 6/5 family");
      end
      if (SETTLE_WORDS == 0) begin : g_bad_settle
         $error("SETTLE_WORDS must be at least 1");
      end
   endgenerate

   logic [3:0]    shamt;
   logic [CW-1:0] base;

   assign shamt  = (rate > 4'(RATE_TOP)) ? 4'd0 : 4'(RATE_TOP) - rate;
   assign base   = alt ? CW'(BASE_ALT) : CW'(BASE_PERIOD);
   assign period = base << shamt;
   assign settle = CW'(period * CW'(SETTLE_WORDS));
   assign delay  = alt ? CW'(DLY_ALT) : CW'(DLY_STD);

endmodule

// File: rtl/conv_scheduler.sv
module conv_scheduler
   import sched_pkg::*;
#(
   parameter int unsigned BASE_PERIOD  = 1280,
   parameter int unsigned DLY_STD      = 1280,
   parameter int unsigned DLY_ALT      = 1536,
   parameter int unsigned SETTLE_WORDS = 3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rate_alt,
   input  logic        reg_we,
   input  logic        reg_wbulk,
   input  logic [1:0]  reg_waddr,
   input  logic [31:0] reg_wdata,
   input  logic        reg_re,
   input  logic        reg_rbulk,
   input  logic [1:0]  reg_raddr,
   output logic [31:0] reg_rdata,
   input  logic        start,
   input  logic [2:0]  start_ptr,
   input  logic        start_cont,
   input  logic        stop,
   output logic [1:0]  latch_out,
   output logic [3:0]  chan_sel,
   output logic [2:0]  gain_sel,
   output logic        unipolar,
   output logic        ocs_en,
   output logic        busy,
   output logic        data_ready,
   output logic        start_ignored
);

   localparam int unsigned MAX_WORD = SETTLE_WORDS * (BASE_PERIOD * 6 / 5) * (1 << RATE_TOP);
   localparam int unsigned MAX_DLY  = (DLY_ALT > DLY_STD) ? DLY_ALT : DLY_STD;
   localparam int unsigned CW       = $clog2(((MAX_WORD > MAX_DLY) ? MAX_WORD : MAX_DLY) + 1);

   setup_t        sel_setup, act_q, calc_src;
   phase_t        ph_q;
   logic [CW-1:0] cnt_q, per_w, settle_w, delay_w;
   logic          alt_q, cont_q, calc_alt, idle;

   sched_setup_bank #(.NREG(4), .RW(32)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (reg_we),
      .wbulk    (reg_wbulk),
      .waddr    (reg_waddr),
      .wdata    (reg_wdata),
      .re       (reg_re),
      .rbulk    (reg_rbulk),
      .raddr    (reg_raddr),
      .rdata    (reg_rdata),
      .sel_ptr  (start_ptr),
      .sel_setup(sel_setup)
   );

   assign idle     = (ph_q == PH_IDLE);
   assign calc_src = idle ? sel_setup : act_q;
   assign calc_alt = idle ? rate_alt : alt_q;

   sched_period_calc #(
      .BASE_PERIOD (BASE_PERIOD),
      .DLY_STD     (DLY_STD),
      .DLY_ALT     (DLY_ALT),
      .SETTLE_WORDS(SETTLE_WORDS),
      .CW          (CW)
   ) u_calc (
      .rate  (calc_src.rate),
      .alt   (calc_alt),
      .period(per_w),
      .settle(settle_w),
      .delay (delay_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q          <= PH_IDLE;
         cnt_q         <= '0;
         act_q         <= '0;
         alt_q         <= 1'b0;
         cont_q        <= 1'b0;
         data_ready    <= 1'b0;
         start_ignored <= 1'b0;
      end else begin
         data_ready <= 1'b0;
         if (start && !idle)
            start_ignored <= 1'b1;
         if (idle) begin
            if (start) begin
               act_q  <= sel_setup;
               alt_q  <= rate_alt;
               cont_q <= start_cont;
               if (sel_setup.dly) begin
                  ph_q  <= PH_DELAY;
                  cnt_q <= delay_w - 1'b1;
               end else begin
                  ph_q  <= PH_SETTLE;
                  cnt_q <= settle_w - 1'b1;
               end
            end
         end else if (stop) begin
            ph_q <= PH_IDLE;
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end else if (ph_q == PH_DELAY) begin
            ph_q  <= PH_SETTLE;
            cnt_q <= settle_w - 1'b1;
         end else begin
            data_ready <= 1'b1;
            if (cont_q) begin
               ph_q  <= PH_RUN;
               cnt_q <= per_w - 1'b1;
            end else begin
               ph_q <= PH_IDLE;
            end
         end
      end
   end

   assign busy      = !idle;
   assign latch_out = act_q.lat;
   assign chan_sel  = act_q.chan;
   assign gain_sel  = act_q.gain;
   assign unipolar  = act_q.unip;
   assign ocs_en    = act_q.ocs;

   // R9: a stop while running ends the sequence on the next edge
   a_r9_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
      busy && stop |=> !busy);

   // R9: no strobe is produced in the cycle following a stop
   a_r9_stop_no_drdy: assert property (@(posedge clk) disable iff (!rst_n)
      busy && stop |=> !data_ready);

   // R10: a start during a run raises the flag
   a_r10_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
      busy && start |=> start_ignored);

   // R10: the flag is sticky until reset
   a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      start_ignored |=> start_ignored);

   // R4: select and latch pins move only on an accepted start
   a_r4_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(start && !busy) |=> $stable(latch_out) && $stable(chan_sel)
                            && $stable(gain_sel) && $stable(unipolar) && $stable(ocs_en));

   // R6: a strobe only follows a cycle in which a sequence was running
   a_r6_drdy_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_ready) |-> $past(busy));

endmodule

// File: tb/conv_scheduler_tb.sv
module conv_scheduler_tb;

   localparam int BASE = 10;
   localparam int DSTD = 20;
   localparam int DALT = 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rate_alt = 1'b0;
   logic        reg_we = 1'b0, reg_wbulk = 1'b0, reg_re = 1'b0, reg_rbulk = 1'b0;
   logic [1:0]  reg_waddr = '0, reg_raddr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        start = 1'b0, start_cont = 1'b0, stop = 1'b0;
   logic [2:0]  start_ptr = '0;
   logic [1:0]  latch_out;
   logic [3:0]  chan_sel;
   logic [2:0]  gain_sel;
   logic        unipolar, ocs_en, busy, data_ready, start_ignored;

   always #10 clk = ~clk;

   conv_scheduler #(.BASE_PERIOD(BASE), .DLY_STD(DSTD), .DLY_ALT(DALT)) u_dut (
      .clk(clk), .rst_n(rst_n), .rate_alt(rate_alt),
      .reg_we(reg_we), .reg_wbulk(reg_wbulk), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
      .reg_re(reg_re), .reg_rbulk(reg_rbulk), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
      .start(start), .start_ptr(start_ptr), .start_cont(start_cont), .stop(stop),
      .latch_out(latch_out), .chan_sel(chan_sel), .gain_sel(gain_sel), .unipolar(unipolar),
      .ocs_en(ocs_en), .busy(busy), .data_ready(data_ready), .start_ignored(start_ignored)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---- reference model: timestamps from the start edge ----
   logic [31:0] m_reg [4];
   int          m_wptr, m_rptr;
   logic [31:0] m_rd;
   logic [15:0] m_act;
   bit          m_busy, m_drdy, m_flag, m_cont;
   longint      cyc, m_next, m_per;
   int          n_drdy;

   function automatic longint word_per(input logic [3:0] rate, input bit alt);
      int b = alt ? BASE * 6 / 5 : BASE;
      int c = (rate > 9) ? 9 : int'(rate);
      return longint'(b) << (9 - c);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) m_reg[i] = 32'h0400_0400;
         m_wptr = 0; m_rptr = 0; m_rd = '0; m_act = '0;
         m_busy = 0; m_drdy = 0; m_flag = 0; m_cont = 0; cyc = 0; m_next = 0; m_per = 0;
      end else begin
         bit          b0;
         logic [15:0] sel;
         cyc++;
         b0  = m_busy;
         sel = start_ptr[0] ? m_reg[start_ptr[2:1]][31:16] : m_reg[start_ptr[2:1]][15:0];
         if (reg_re) begin
            m_rd   = m_reg[reg_rbulk ? m_rptr : int'(reg_raddr)];
            m_rptr = reg_rbulk ? (m_rptr + 1) % 4 : 0;
         end
         if (reg_we) begin
            m_reg[reg_wbulk ? m_wptr : int'(reg_waddr)] = reg_wdata;
            m_wptr = reg_wbulk ? (m_wptr + 1) % 4 : 0;
         end
         m_drdy = 0;
         if (start && b0) m_flag = 1;
         if (b0) begin
            if (stop) m_busy = 0;
            else if (cyc == m_next) begin
               m_drdy = 1;
               if (m_cont) m_next += m_per; else m_busy = 0;
            end
         end else if (start) begin
            m_act  = sel;
            m_busy = 1;
            m_cont = start_cont;
            m_per  = word_per(sel[11:8], rate_alt);
            m_next = cyc + 3 * m_per + (sel[15] ? (rate_alt ? DALT : DSTD) : 0);
         end
      end
   end

   // ---- per-cycle comparison ----
   always @(negedge clk) begin
      if (rst_n) begin
         if (data_ready) n_drdy++;
         chk(busy == m_busy, "R6 R7 R9 busy", 32'(busy), 32'(m_busy));
         chk(data_ready == m_drdy, "R5 R6 R7 R8 data_ready", 32'(data_ready), 32'(m_drdy));
         chk(start_ignored == m_flag, "R10 start_ignored", 32'(start_ignored), 32'(m_flag));
         chk({ocs_en, latch_out, unipolar, gain_sel, chan_sel} ==
             {m_act[14], m_act[13:12], m_act[7], m_act[6:4], m_act[3:0]},
             "R4 select pins", {21'd0, ocs_en, latch_out, unipolar, gain_sel, chan_sel},
             {21'd0, m_act[14], m_act[13:12], m_act[7], m_act[6:4], m_act[3:0]});
         chk(reg_rdata == m_rd, "R2 R3 reg_rdata", reg_rdata, m_rd);
      end
   end

   // ---- stimulus helpers ----
   function automatic logic [15:0] mk(input int ch, input int g, input bit u, input int rate,
                                      input int lat, input bit ocs, input bit dly);
      return {dly, ocs, 2'(lat), 4'(rate), u, 3'(g), 4'(ch)};
   endfunction

   task automatic wr(input bit bulk, input int a, input logic [31:0] d);
      @(negedge clk); reg_we = 1; reg_wbulk = bulk; reg_waddr = 2'(a); reg_wdata = d;
      @(negedge clk); reg_we = 0; reg_wbulk = 0;
   endtask

   task automatic rd(input bit bulk, input int a);
      @(negedge clk); reg_re = 1; reg_rbulk = bulk; reg_raddr = 2'(a);
      @(negedge clk); reg_re = 0; reg_rbulk = 0;
   endtask

   task automatic go(input int ptr, input bit cont, input bit alt);
      @(negedge clk); start = 1; start_ptr = 3'(ptr); start_cont = cont; rate_alt = alt;
      @(negedge clk); start = 0;
   endtask

   task automatic halt();
      @(negedge clk); stop = 1;
      @(negedge clk); stop = 0;
   endtask

   task automatic idle_wait(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      n_drdy = 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(busy == 0 && data_ready == 0 && start_ignored == 0, "R1 status after reset",
          {29'd0, busy, data_ready, start_ignored}, 32'd0);
      chk({latch_out, chan_sel, gain_sel, unipolar, ocs_en} == '0, "R1 pins after reset",
          32'({latch_out, chan_sel, gain_sel, unipolar, ocs_en}), 32'd0);
      rst_n = 1;
      for (int i = 0; i < 4; i++) begin
         rd(0, i);
         chk(reg_rdata == 32'h0400_0400, "R1 default register", reg_rdata, 32'h0400_0400);
      end

      // R2: single writes and halves
      wr(0, 1, {mk(2, 1, 0, 8, 2, 0, 1), mk(3, 5, 1, 9, 1, 1, 0)});
      rd(0, 1);
      chk(reg_rdata == {mk(2, 1, 0, 8, 2, 0, 1), mk(3, 5, 1, 9, 1, 1, 0)}, "R2 readback",
          reg_rdata, {mk(2, 1, 0, 8, 2, 0, 1), mk(3, 5, 1, 9, 1, 1, 0)});

      // R3: bulk write then bulk read
      wr(1, 0, {mk(5, 2, 0, 9, 3, 0, 1), mk(1, 0, 0, 0, 0, 0, 0)});
      wr(1, 0, {mk(2, 1, 0, 8, 2, 0, 1), mk(3, 5, 1, 9, 1, 1, 0)});
      wr(1, 0, {mk(7, 7, 1, 12, 3, 1, 0), mk(4, 3, 1, 7, 1, 0, 0)});
      wr(1, 0, {mk(6, 6, 0, 9, 0, 1, 1), mk(8, 4, 0, 8, 2, 0, 0)});
      for (int i = 0; i < 5; i++) rd(1, 0);
      rd(0, 3);
      rd(1, 0);

      // R4 R6: single mode, rate 9, base family (setup 2)
      n_drdy = 0;
      go(2, 0, 0);
      idle_wait(5);
      wr(0, 1, 32'h0);
      idle_wait(40);
      chk(n_drdy == 1, "R6 one strobe in single mode", 32'(n_drdy), 32'd1);
      wr(0, 1, {mk(2, 1, 0, 8, 2, 0, 1), mk(3, 5, 1, 9, 1, 1, 0)});

      // R8 R5: single, delay set, stretched family (setup 3: rate 8)
      go(3, 0, 1);
      idle_wait(120);

      // R7: continuous, rate 8, base family, delay (setup 3), then stop
      n_drdy = 0;
      go(3, 1, 0);
      idle_wait(20 + 60 + 4 * 20 + 5);
      chk(n_drdy == 5, "R7 continuous strobe count", 32'(n_drdy), 32'd5);
      // R10: start while running
      go(0, 0, 0);
      chk(start_ignored == 1, "R10 flag after busy start", 32'(start_ignored), 32'd1);
      idle_wait(7);
      halt();
      n_drdy = 0;
      idle_wait(60);
      chk(n_drdy == 0 && busy == 0, "R9 no strobes after stop", 32'(n_drdy), 32'd0);
      // R9: stop while idle
      halt();
      chk(busy == 0, "R9 idle stop harmless", 32'(busy), 32'd0);

      // R5: code 12 behaves as code 9 (setup 5), continuous in stretched family
      go(5, 1, 1);
      idle_wait(36 + 3 * 12 + 3);
      halt();
      idle_wait(3);

      // R5: slowest code 0 single (setup 0)
      n_drdy = 0;
      go(0, 0, 0);
      idle_wait(3 * 5120 + 5);
      chk(n_drdy == 1, "R5 slowest-rate single strobe", 32'(n_drdy), 32'd1);
      chk(start_ignored == 1, "R10 flag still set", 32'(start_ignored), 32'd1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule